// File: doc/BRIEF.md
# PC Card Bus Access Controller

This block turns single host read and write requests into 16-bit PC Card bus cycles. A request names one of three card spaces (common memory, attribute memory, I/O), a transfer size, an address, write data and a direction. The controller decodes these into the chip-enable, register-select and strobe pattern that the card expects. It then runs the cycle through a fixed sequence of setup, access and hold, and reports completion with a one-cycle done pulse. Read data is returned with that pulse.

Requests that the card bus cannot carry get no bus activity. These are a byte on the upper data lane, a word at an odd address, an attribute access at an odd address and reserved codes. The controller answers them with done and an error flag one cycle after the request. Each space has its own access-phase length, supplied as an input. When waiting is enabled, the card can hold its wait line low to stretch the access phase. That line passes through a two-stage synchronizer before the controller acts on it.

Top module: `pcc_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is in progress, every active-low card control output is high, done and error are low, and the controller does not drive the data bus.
- R2: A lower-lane byte (size code 0) drives chip-enable 1 low and chip-enable 2 high, and carries data on D7-D0 at even or odd addresses in common and I/O space. Write data is driven as {8'h00, wdata[7:0]}, and read data returns as {8'h00, D7-D0}.
- R3: A word (size code 2) at an even address drives both chip-enables low and moves all 16 data bits in both directions.
- R4: Common and attribute cycles strobe output-enable for reads and write-enable for writes, with the I/O strobes high. I/O cycles strobe I/O-read or I/O-write, with output-enable and write-enable high.
- R5: Register-select is high for common memory (space code 0) and low for attribute (space code 1) and I/O (space code 2) cycles.
- R6: An attribute access at an odd address is refused. The same access at an even address runs normally.
- R7: A refused request gets done and error together in the first cycle after the request, with no chip-enable or strobe ever asserted. Refused requests are an upper-lane byte (size code 1), size code 3, a word at an odd address, space code 3, and the R6 case. Chip-enable 2 is never low without chip-enable 1.
- R8: With waiting disabled, the strobe stays low for exactly N cycles. N is the access length input of the addressed space, and a value of 0 acts as 1.
- R9: With waiting enabled and N of at least 3, suppose the card pulls the wait line low in the first strobe cycle and keeps it low for W cycles. The strobe is then low for max(N, W+3) cycles, and read data is taken on the last of them.
- R10: With waiting disabled, the wait line has no effect on the strobe length.
- R11: Every accepted cycle has exactly one setup cycle, with chip-enables and address valid and the strobe high. It also has exactly one hold cycle after the strobe rises, with chip-enables still low. Done is a single-cycle pulse in the cycle after hold. Write data is on the bus through setup, strobe and hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, one cycle, accepted when idle |
| space_i | input | 2 | 0 common, 1 attribute, 2 I/O, 3 reserved |
| size_i | input | 2 | 0 lower byte, 1 upper byte, 2 word, 3 reserved |
| addr_i | input | AW | Card address |
| wdata_i | input | DW | Write data |
| write_i | input | 1 | 1 write, 0 read |
| wait_en_i | input | 1 | Enables stretching through the wait line |
| mem_len_i | input | LW | Access length for common memory |
| att_len_i | input | LW | Access length for attribute memory |
| io_len_i | input | LW | Access length for I/O |
| rdata_o | output | DW | Read data, valid with done |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set with done when a request is refused |
| ce1_n_o | output | 1 | Chip-enable 1, active low |
| ce2_n_o | output | 1 | Chip-enable 2, active low |
| reg_n_o | output | 1 | Register/attribute select, active low |
| oe_n_o | output | 1 | Memory read strobe, active low |
| we_n_o | output | 1 | Memory write strobe, active low |
| iord_n_o | output | 1 | I/O read strobe, active low |
| iowr_n_o | output | 1 | I/O write strobe, active low |
| addr_o | output | AW | Card address bus |
| data_io | inout | DW | Card data bus |
| wait_n_i | input | 1 | Card wait request, active low, asynchronous |

## Verification
The bench uses the default AW of 11, DW of 16 and LW of 8, with different access lengths per space: 3 for common, 5 for attribute and 4 for I/O. With three distinct lengths, a wrong length mux shows up as a wrong strobe count. Waits of 1 and 6 cycles fall on both sides of the programmed lengths, so both terms of max(N, W+3) are reached. A card model answers reads with data derived from the address, which exposes lane selection and bus contention.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [1:0] {
    SP_COMMON = 2'd0,
    SP_ATTR   = 2'd1,
    SP_IO     = 2'd2,
    SP_RSVD   = 2'd3
  } pcc_space_e;

  typedef enum logic [1:0] {
    SZ_BYTE_LO = 2'd0,
    SZ_BYTE_HI = 2'd1,
    SZ_WORD    = 2'd2,
    SZ_RSVD    = 2'd3
  } pcc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_DONE
  } pcc_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2_n;
    logic reg_n;
    logic io;
    logic word;
    logic bad;
  } pcc_pat_t;

endpackage

// File: rtl/pcc_decode.sv
module pcc_decode
  import pcc_pkg::*;
(
  input  logic [1:0] space_i,
  input  logic [1:0] size_i,
  input  logic       a0_i,
  output pcc_pat_t   pat_o
);
  always_comb begin
    pat_o = '{ce1_n: 1'b0, ce2_n: 1'b1, reg_n: 1'b1, io: 1'b0, word: 1'b0, bad: 1'b0};
    unique case (pcc_space_e'(space_i))
      SP_COMMON: pat_o.reg_n = 1'b1;
      SP_ATTR: begin
        pat_o.reg_n = 1'b0;
        if (a0_i) pat_o.bad = 1'b1;
      end
      SP_IO: begin
        pat_o.reg_n = 1'b0;
        pat_o.io    = 1'b1;
      end
      default: pat_o.bad = 1'b1;
    endcase
    unique case (pcc_size_e'(size_i))
      SZ_BYTE_LO: pat_o.ce2_n = 1'b1;
      SZ_WORD: begin
        pat_o.ce2_n = 1'b0;
        pat_o.word  = 1'b1;
        if (a0_i) pat_o.bad = 1'b1;
      end
      default: pat_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pcc_wsync.sv
module pcc_wsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic dout_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= din_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], din_i};
      end
    end
  endgenerate

  assign dout_o = sh_q[STAGES-1];
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import pcc_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          bad_i,
  input  logic [LW-1:0] len_i,
  input  logic          wait_ok_i,
  output pcc_state_e    state_q_o,
  output pcc_state_e    state_d_o,
  output logic          leave_o
);
  pcc_state_e    st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    leave_o = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = bad_i ? ST_DONE : ST_SETUP;
      ST_SETUP: begin
        st_d  = ST_ACCESS;
        cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
      end
      ST_ACCESS: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (wait_ok_i) begin
          st_d    = ST_HOLD;
          leave_o = 1'b1;
        end
      end
      ST_HOLD:   st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_q_o = st_q;
  assign state_d_o = st_d;
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [1:0]    space_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          write_i,
  input  logic          wait_en_i,
  input  logic [LW-1:0] mem_len_i,
  input  logic [LW-1:0] att_len_i,
  input  logic [LW-1:0] io_len_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic          ce1_n_o,
  output logic          ce2_n_o,
  output logic          reg_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic          iord_n_o,
  output logic          iowr_n_o,
  output logic [AW-1:0] addr_o,
  inout  wire  [DW-1:0] data_io,
  input  logic          wait_n_i
);
  localparam int BW = DW / 2;

  pcc_pat_t      dec_pat, pat_q, cur_pat;
  logic [1:0]    space_q, cur_space;
  logic [AW-1:0] addr_q, cur_addr;
  logic [DW-1:0] wdata_q, cur_wdata;
  logic          write_q, cur_write;
  logic [LW-1:0] len_sel;
  logic          wait_sync, wait_ok, leave, start, active;
  pcc_state_e    st_q, st_d;
  logic          drv_q;
  logic [DW-1:0] dout_q;

  pcc_decode u_dec (
    .space_i (space_i),
    .size_i  (size_i),
    .a0_i    (addr_i[0]),
    .pat_o   (dec_pat)
  );

  pcc_wsync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk    (clk),
    .rst    (rst),
    .din_i  (wait_n_i),
    .dout_o (wait_sync)
  );

  assign start   = req_i && (st_q == ST_IDLE);
  assign wait_ok = !wait_en_i || wait_sync;

  always_comb begin
    unique case (pcc_space_e'(space_q))
      SP_ATTR: len_sel = att_len_i;
      SP_IO:   len_sel = io_len_i;
      default: len_sel = mem_len_i;
    endcase
  end

  pcc_seq #(.LW(LW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .bad_i     (dec_pat.bad),
    .len_i     (len_sel),
    .wait_ok_i (wait_ok),
    .state_q_o (st_q),
    .state_d_o (st_d),
    .leave_o   (leave)
  );

  // Request fields as seen by the next state: live when idle, latched otherwise.
  assign cur_pat   = (st_q == ST_IDLE) ? dec_pat : pat_q;
  assign cur_space = (st_q == ST_IDLE) ? space_i : space_q;
  assign cur_addr  = (st_q == ST_IDLE) ? addr_i  : addr_q;
  assign cur_wdata = (st_q == ST_IDLE) ? wdata_i : wdata_q;
  assign cur_write = (st_q == ST_IDLE) ? write_i : write_q;
  assign active    = (st_d == ST_SETUP) || (st_d == ST_ACCESS) || (st_d == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q   <= '{ce1_n: 1'b1, ce2_n: 1'b1, reg_n: 1'b1, io: 1'b0, word: 1'b0, bad: 1'b0};
      space_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (start) begin
      pat_q   <= dec_pat;
      space_q <= space_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      write_q <= write_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce1_n_o  <= 1'b1;
      ce2_n_o  <= 1'b1;
      reg_n_o  <= 1'b1;
      oe_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      iord_n_o <= 1'b1;
      iowr_n_o <= 1'b1;
      addr_o   <= '0;
      drv_q    <= 1'b0;
      dout_q   <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ce1_n_o  <= !(active && !cur_pat.ce1_n);
      ce2_n_o  <= !(active && !cur_pat.ce2_n);
      reg_n_o  <= !(active && !cur_pat.reg_n);
      oe_n_o   <= !(st_d == ST_ACCESS && !cur_pat.io && !cur_write);
      we_n_o   <= !(st_d == ST_ACCESS && !cur_pat.io &&  cur_write);
      iord_n_o <= !(st_d == ST_ACCESS &&  cur_pat.io && !cur_write);
      iowr_n_o <= !(st_d == ST_ACCESS &&  cur_pat.io &&  cur_write);
      if (active) addr_o <= cur_addr;
      drv_q    <= active && cur_write;
      if (active)
        dout_q <= cur_pat.word ? cur_wdata : {{(DW-BW){1'b0}}, cur_wdata[BW-1:0]};
      done_o   <= (st_d == ST_DONE);
      err_o    <= (st_d == ST_DONE) && (st_q == ST_IDLE);
      if (leave)
        rdata_o <= pat_q.word ? data_io : {{(DW-BW){1'b0}}, data_io[BW-1:0]};
    end
  end

  assign data_io = drv_q ? dout_q : {DW{1'bz}};

  logic unused_space;
  assign unused_space = ^cur_space;
endmodule

// File: rtl/pcc_ctrl_chk.sv
module pcc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ce1_n,
  input logic ce2_n,
  input logic reg_n,
  input logic oe_n,
  input logic we_n,
  input logic iord_n,
  input logic iowr_n,
  input logic done,
  input logic err
);
  logic mem_strobe, io_strobe, strobes_idle;
  assign mem_strobe   = !oe_n || !we_n;
  assign io_strobe    = !iord_n || !iowr_n;
  assign strobes_idle = !mem_strobe && !io_strobe;

  // R7: chip-enable 2 never asserted alone
  a_r7_no_lone_ce2: assert property (@(posedge clk) disable iff (rst)
    !ce2_n |-> !ce1_n);

  // R4: memory and I/O strobe families never overlap
  a_r4_strobe_families: assert property (@(posedge clk) disable iff (rst)
    !(mem_strobe && io_strobe));

  // R5: I/O strobes come with register-select low
  a_r5_io_reg_low: assert property (@(posedge clk) disable iff (rst)
    io_strobe |-> !reg_n);

  // R11: a strobe only inside a chip-enable window
  a_r11_strobe_in_ce: assert property (@(posedge clk) disable iff (rst)
    !strobes_idle |-> !ce1_n);

  // R11: hold cycle keeps chip-enable low after the strobe rises
  a_r11_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(strobes_idle) |-> !ce1_n);

  // R11: done lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: error only with done, and a refusal leaves the bus quiet
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  a_r7_refusal_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (ce1_n && ce2_n && strobes_idle));
endmodule

bind pcc_ctrl pcc_ctrl_chk u_pcc_ctrl_chk (
  .clk    (clk),
  .rst    (rst),
  .ce1_n  (ce1_n_o),
  .ce2_n  (ce2_n_o),
  .reg_n  (reg_n_o),
  .oe_n   (oe_n_o),
  .we_n   (we_n_o),
  .iord_n (iord_n_o),
  .iowr_n (iowr_n_o),
  .done   (done_o),
  .err    (err_o)
);

// File: tb/test_pcc_ctrl.sv
module test_pcc_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] space = '0, size = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic write = 1'b0, wait_en = 1'b0;
  logic [LW-1:0] mem_len = 8'd3, att_len = 8'd5, io_len = 8'd4;
  logic [DW-1:0] rdata;
  logic done, err, ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n;
  logic [AW-1:0] caddr;
  wire  [DW-1:0] card_d;
  logic wait_n = 1'b1;

  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  pcc_ctrl #(.AW(AW), .DW(DW), .LW(LW)) i_pcc_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .space_i(space), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .write_i(write), .wait_en_i(wait_en),
    .mem_len_i(mem_len), .att_len_i(att_len), .io_len_i(io_len),
    .rdata_o(rdata), .done_o(done), .err_o(err),
    .ce1_n_o(ce1_n), .ce2_n_o(ce2_n), .reg_n_o(reg_n), .oe_n_o(oe_n),
    .we_n_o(we_n), .iord_n_o(iord_n), .iowr_n_o(iowr_n),
    .addr_o(caddr), .data_io(card_d), .wait_n_i(wait_n)
  );

  // Card model: read data derived from the address
  logic card_rd;
  assign card_rd = !oe_n || !iord_n;
  assign card_d  = card_rd ? {caddr[7:0] ^ 8'h5A, caddr[7:0]} : {DW{1'bz}};

  // Wait model
  int w_len = 0;
  int w_cnt = 0;
  bit w_used = 0;
  logic strobe_low;
  assign strobe_low = !oe_n || !we_n || !iord_n || !iowr_n;

  always @(negedge clk) begin
    if (ce1_n && ce2_n) w_used <= 0;
    if (w_cnt > 0) begin
      w_cnt = w_cnt - 1;
      if (w_cnt == 0) wait_n <= 1'b1;
    end else if (strobe_low && !w_used && w_len > 0) begin
      wait_n <= 1'b0;
      w_cnt = w_len;
      w_used <= 1;
    end
  end

  // Bus monitor
  int m_pre, m_low, m_post;
  bit m_seen, m_any_strobe;
  logic [6:0] m_pat;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_d_set, m_d_str, m_d_hold;

  always @(negedge clk) begin
    if (req) begin
      m_pre = 0; m_low = 0; m_post = 0; m_seen = 0; m_any_strobe = 0;
    end else begin
      if (strobe_low) m_any_strobe = 1;
      if (!ce1_n || !ce2_n) begin
        if (strobe_low) begin
          m_low++;
          m_seen = 1;
          m_pat  = {ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n};
          m_addr = caddr;
          m_d_str = card_d;
        end else if (m_seen) begin
          m_post++;
          m_d_hold = card_d;
        end else begin
          m_pre++;
          m_d_set = card_d;
        end
      end
    end
  end

  task automatic chk(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_pat(input int sp, input int sz, input bit wr);
    bit io = (sp == 2);
    return {1'b0, (sz == 2) ? 1'b0 : 1'b1, (sp == 0) ? 1'b1 : 1'b0,
            !(!io && !wr), !(!io && wr), !(io && !wr), !(io && wr)};
  endfunction

  int o_cycles;
  logic o_err;
  logic [DW-1:0] o_rdata;

  task automatic run(input int sp, input int sz, input int a, input int wd, input bit wr);
    @(posedge clk); #1;
    space = sp[1:0]; size = sz[1:0]; addr = a[AW-1:0]; wdata = wd[DW-1:0]; write = wr;
    req = 1'b1;
    @(posedge clk); #1;
    req = 1'b0;
    o_cycles = 0;
    o_err = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      o_cycles++;
      if (done) begin
        o_err = err;
        o_rdata = rdata;
        break;
      end
    end
    if (!done) chk("watchdog", 1'b0, o_cycles, 0);
  endtask

  // Accepted transfer with full checks; L is the expected strobe length
  task automatic good(input string rq, input int sp, input int sz, input int a,
                      input int wd, input bit wr, input int L);
    logic [DW-1:0] exp_d;
    run(sp, sz, a, wd, wr);
    chk({rq, " no error"}, o_err == 1'b0, o_err, 0);
    chk({rq, " pattern (R4 R5)"}, m_pat == exp_pat(sp, sz, wr), m_pat, exp_pat(sp, sz, wr));
    chk({rq, " address"}, m_addr == a[AW-1:0], m_addr, a);
    chk({rq, " strobe length (R8)"}, m_low == L, m_low, L);
    chk({rq, " setup/hold R11"}, m_pre == 1 && m_post == 1, {m_pre[15:0], m_post[15:0]}, 32'h0001_0001);
    chk({rq, " done latency R11"}, o_cycles == L + 3, o_cycles, L + 3);
    if (wr) begin
      exp_d = (sz == 2) ? wd[DW-1:0] : {8'h00, wd[7:0]};
      chk({rq, " write data R11"}, m_d_set == exp_d && m_d_str == exp_d && m_d_hold == exp_d,
          m_d_str, exp_d);
    end else begin
      exp_d = (sz == 2) ? {a[7:0] ^ 8'h5A, a[7:0]} : {8'h00, a[7:0]};
      chk({rq, " read data"}, o_rdata == exp_d, o_rdata, exp_d);
    end
  endtask

  task automatic refused(input string rq, input int sp, input int sz, input int a, input bit wr);
    run(sp, sz, a, 16'hA55A, wr);
    chk({rq, " R7 error"}, o_err == 1'b1, o_err, 1);
    chk({rq, " R7 latency"}, o_cycles == 1, o_cycles, 1);
    chk({rq, " R7 quiet bus"}, !m_any_strobe && (m_pre + m_low + m_post) == 0,
        m_pre + m_low + m_post, 0);
  endtask

  task automatic t_reset();
    chk("R1 controls idle", {ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n} == 7'h7F,
        {ce1_n, ce2_n, reg_n, oe_n, we_n, iord_n, iowr_n}, 7'h7F);
    chk("R1 done/err low", !done && !err, {done, err}, 0);
  endtask

  task automatic t_common();
    good("R2 common byte write odd", 0, 0, 'h035, 'h12C7, 1, 3);
    good("R2 common byte read odd", 0, 0, 'h035, 0, 0, 3);
    good("R3 common word write", 0, 2, 'h040, 'hBEEF, 1, 3);
    good("R3 common word read", 0, 2, 'h046, 0, 0, 3);
  endtask

  task automatic t_attr();
    good("R6 attr config read even", 1, 0, 'h200, 0, 0, 5);
    good("R6 attr cis write even", 1, 0, 'h004, 'h0077, 1, 5);
    refused("R6 attr odd read", 1, 0, 'h201, 0);
  endtask

  task automatic t_io();
    good("R2 io byte read odd", 2, 0, 'h011, 0, 0, 4);
    good("R2 io byte write even", 2, 0, 'h010, 'h3399, 1, 4);
    good("R3 io word write", 2, 2, 'h020, 'hC0DE, 1, 4);
    good("R3 io word read", 2, 2, 'h022, 0, 0, 4);
  endtask

  task automatic t_refuse();
    refused("R7 common upper byte", 0, 1, 'h031, 1);
    refused("R7 io upper byte", 2, 1, 'h011, 0);
    refused("R7 odd word", 0, 2, 'h033, 0);
    refused("R7 reserved space", 3, 0, 'h010, 0);
    refused("R7 reserved size", 0, 3, 'h010, 1);
    good("R1 recovers after refusal", 0, 0, 'h012, 0, 0, 3);
  endtask

  task automatic t_len();
    mem_len = 8'd0;
    good("R8 zero length acts as one", 0, 0, 'h00A, 0, 0, 1);
    mem_len = 8'd7;
    good("R8 long length", 0, 2, 'h00C, 'h1234, 1, 7);
    mem_len = 8'd3;
  endtask

  task automatic t_wait();
    wait_en = 1'b1;
    w_len = 6;
    good("R9 io wait stretches", 2, 0, 'h013, 0, 0, 9);
    w_len = 1;
    good("R9 short wait mem", 0, 2, 'h050, 0, 0, 4);
    good("R9 short wait under attr length", 1, 0, 'h008, 0, 0, 5);
    w_len = 0;
    good("R9 no wait asserted", 2, 0, 'h014, 0, 0, 4);
    wait_en = 1'b0;
    w_len = 6;
    good("R10 wait ignored", 2, 0, 'h015, 0, 0, 4);
    w_len = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_common();
    t_attr();
    t_io();
    t_refuse();
    t_len();
    t_wait();
    repeat (3) @(negedge clk);
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule